// File: doc/BRIEF.md
# Holdover Exit Frequency Ramp

This block moves a frequency-control word from a starting value to a new value. It is used when a clock loop leaves holdover or changes to a different input. When a start strobe arrives, it captures two words: the frequency the loop currently holds, and the frequency it must reach. It measures the gap between them. From that gap and the selected step magnitude it works out how many steps the ramp needs. It then moves its output toward the target in equal steps at a fixed tick interval. The final step is clipped, so the output lands exactly on the target and never passes it.

Two small codes set the ramp rate. A 3-bit step code sets the step magnitude, and a 3-bit interval code sets the clock cycles between steps. The same codes serve both holdover exit and input switching.

A bypass bit replaces the ramp with a bandwidth choice. The output jumps at once to the target, and a 2-bit exit-bandwidth field tells the loop filter which of three bandwidths to use while it relocks. The loop filter itself is outside this block.

Top module: `freq_exit_ramp`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, done, freqOut and exitBw are all zero.
- R2: A start accepted with bypass low and a nonzero difference has these effects one cycle later: freqOut equals the captured holdFreq, busy is 1, done is 0, and exitBw is 2'b00 (ramped exit).
- R3: Step code c gives a step magnitude of 4^c (1 << 2c). Interval code t gives 2^t clock cycles between steps. The first step takes effect 2^t cycles after the edge that accepted the start.
- R4: The ramp direction follows the sign of (target − hold). Every step except the last has exactly the step magnitude. The output is monotonic and never passes the target.
- R5: The ramp has ceil(|target − hold| / magnitude) steps. The last step is clipped to land on the target. In the cycle that step takes effect, busy falls and done rises. Busy and done are never high together.
- R6: A start with bypass low and holdFreq equal to targetFreq has these effects one cycle later: done is 1, busy is 0, and freqOut equals the target.
- R7: A start with bypass high has these effects one cycle later: freqOut equals targetFreq, done is 1, and busy is 0. exitBw is set from bwSel as follows: 00 gives 2'b01 (fastlock), 01 gives 2'b10 (holdover-exit), and 10 or 11 give 2'b11 (normal loop bandwidth).
- R8: A start strobe while busy is high is ignored, including one that coincides with the final step. Done stays high until the next accepted start.
- R9: The frequency words and codes are captured when a start is accepted. Changing them during a ramp does not alter its steps or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start request, accepted only when not busy |
| holdFreq | input | FREQ_W | Current holdover frequency word |
| targetFreq | input | FREQ_W | Desired new frequency word |
| stepCode | input | CODE_W | Step magnitude code |
| tickCode | input | CODE_W | Step interval code |
| bypass | input | 1 | 1 selects an exit bandwidth instead of a ramp |
| bwSel | input | 2 | Exit-bandwidth selection used when bypass is high |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | Last exit finished; held until the next accepted start |
| freqOut | output | FREQ_W | Frequency-control word driven to the loop |
| exitBw | output | 2 | 00 ramped, 01 fastlock, 10 holdover-exit, 11 normal |

## Verification
Two functions can fall in the same cycle: the final, clipped step, and the acceptance of a new start strobe. The bench raises startStb so that it is sampled at the very edge where the last step lands. The bench then judges that the output still lands on the old target, that done rises, and that no new ramp begins. It also sends a start in the middle of a ramp with bypass high, altered frequency words and altered codes. The remaining steps must keep the original magnitude and interval, and exitBw must stay at the ramped value.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef struct packed {
    logic load;   // capture words and begin a ramp
    logic jump;   // bypass: go straight to the target
    logic step;   // advance one step toward the target
  } rampStb_t;

  typedef enum logic [1:0] {
    BW_RAMPED   = 2'b00,
    BW_FAST     = 2'b01,
    BW_HOLDEXIT = 2'b10,
    BW_NORMAL   = 2'b11
  } exitBw_e;

  function automatic exitBw_e decodeBw(input logic [1:0] sel);
    case (sel)
      2'b00:   return BW_FAST;
      2'b01:   return BW_HOLDEXIT;
      default: return BW_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/frx_datapath.sv
module frx_datapath
  import frx_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampStb_t          stb,
  input  logic [FREQ_W-1:0] holdFreq,
  input  logic [FREQ_W-1:0] targetFreq,
  input  logic [CODE_W-1:0] stepCode,
  input  logic [1:0]        bwSel,
  output logic              zeroDiff,
  output logic              lastStep,
  output logic [FREQ_W-1:0] freqOut,
  output logic [1:0]        exitBw
);
  localparam int CNT_W = FREQ_W + 1;
  localparam int SH_W  = CODE_W + 1;

  logic [FREQ_W-1:0] diffMag;
  logic [SH_W-1:0]   shiftIn;
  logic [CNT_W-1:0]  magIn;
  logic [CNT_W-1:0]  stepsIn;

  logic [FREQ_W-1:0] freqReg;
  logic [FREQ_W-1:0] targetReg;
  logic [FREQ_W-1:0] magReg;
  logic              upReg;
  logic [CNT_W-1:0]  remain;
  exitBw_e           bwReg;

  // Measure the gap and derive the step count before the ramp starts.
  always_comb begin
    diffMag = (targetFreq >= holdFreq) ? (targetFreq - holdFreq) : (holdFreq - targetFreq);
    shiftIn = {stepCode, 1'b0};
    magIn   = CNT_W'(1) << shiftIn;
    stepsIn = ({1'b0, diffMag} + magIn - CNT_W'(1)) >> shiftIn;
  end

  assign zeroDiff = (diffMag == '0);
  assign lastStep = (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqReg   <= '0;
      targetReg <= '0;
      magReg    <= '0;
      upReg     <= 1'b0;
      remain    <= '0;
      bwReg     <= BW_RAMPED;
    end else if (stb.jump) begin
      freqReg <= targetFreq;
      remain  <= '0;
      bwReg   <= decodeBw(bwSel);
    end else if (stb.load) begin
      freqReg   <= holdFreq;
      targetReg <= targetFreq;
      upReg     <= (targetFreq >= holdFreq);
      magReg    <= magIn[FREQ_W-1:0];
      remain    <= stepsIn;
      bwReg     <= BW_RAMPED;
    end else if (stb.step) begin
      remain <= remain - CNT_W'(1);
      if (lastStep)   freqReg <= targetReg;
      else if (upReg) freqReg <= freqReg + magReg;
      else            freqReg <= freqReg - magReg;
    end
  end

  assign freqOut = freqReg;
  assign exitBw  = bwReg;

endmodule

// File: rtl/frx_ctrl.sv
module frx_ctrl
  import frx_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              bypass,
  input  logic [CODE_W-1:0] tickCode,
  input  logic              zeroDiff,
  input  logic              lastStep,
  output rampStb_t          stb,
  output logic              busy,
  output logic              done
);
  localparam int TICK_W = 1 << CODE_W;

  typedef enum logic {ST_IDLE, ST_RAMP} state_e;

  state_e            state;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] tickReload;
  logic [TICK_W-1:0] reloadIn;
  logic              accept;

  always_comb begin
    accept   = startStb && (state == ST_IDLE);
    reloadIn = (TICK_W'(1) << tickCode) - TICK_W'(1);
    stb.jump = accept && bypass;
    stb.load = accept && !bypass;
    stb.step = (state == ST_RAMP) && (tickCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tickCnt    <= '0;
      tickReload <= '0;
      done       <= 1'b0;
    end else if (accept) begin
      if (bypass || zeroDiff) begin
        done <= 1'b1;
      end else begin
        state      <= ST_RAMP;
        done       <= 1'b0;
        tickReload <= reloadIn;
        tickCnt    <= reloadIn;
      end
    end else if (state == ST_RAMP) begin
      if (tickCnt == '0) begin
        tickCnt <= tickReload;
        if (lastStep) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end else begin
        tickCnt <= tickCnt - TICK_W'(1);
      end
    end
  end

  assign busy = (state == ST_RAMP);

endmodule

// File: rtl/freq_exit_ramp.sv
module freq_exit_ramp
  import frx_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [FREQ_W-1:0] holdFreq,
  input  logic [FREQ_W-1:0] targetFreq,
  input  logic [CODE_W-1:0] stepCode,
  input  logic [CODE_W-1:0] tickCode,
  input  logic              bypass,
  input  logic [1:0]        bwSel,
  output logic              busy,
  output logic              done,
  output logic [FREQ_W-1:0] freqOut,
  output logic [1:0]        exitBw
);
  rampStb_t stb;
  logic     zeroDiff;
  logic     lastStep;

  frx_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .bypass(bypass),
    .tickCode(tickCode), .zeroDiff(zeroDiff), .lastStep(lastStep),
    .stb(stb), .busy(busy), .done(done)
  );

  frx_datapath #(.FREQ_W(FREQ_W), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .holdFreq(holdFreq),
    .targetFreq(targetFreq), .stepCode(stepCode), .bwSel(bwSel),
    .zeroDiff(zeroDiff), .lastStep(lastStep), .freqOut(freqOut), .exitBw(exitBw)
  );

endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
  parameter int FREQ_W = 24,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStb,
  input logic [FREQ_W-1:0] holdFreq,
  input logic [FREQ_W-1:0] targetFreq,
  input logic [CODE_W-1:0] stepCode,
  input logic              bypass,
  input logic              busy,
  input logic              done,
  input logic [FREQ_W-1:0] freqOut,
  input logic [1:0]        exitBw
);
  logic [FREQ_W-1:0] capTarget;
  logic [FREQ_W-1:0] capMag;
  logic [FREQ_W-1:0] distNow;
  logic [FREQ_W-1:0] prevFreq;
  logic [FREQ_W-1:0] distPrev;
  logic [FREQ_W-1:0] moveAbs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capTarget <= '0;
      capMag    <= '0;
      prevFreq  <= '0;
    end else begin
      prevFreq <= freqOut;
      if (startStb && !busy) begin
        capTarget <= targetFreq;
        capMag    <= FREQ_W'(1) << {stepCode, 1'b0};
      end
    end
  end

  always_comb begin
    distNow  = (freqOut  >= capTarget) ? freqOut - capTarget  : capTarget - freqOut;
    distPrev = (prevFreq >= capTarget) ? prevFreq - capTarget : capTarget - prevFreq;
    moveAbs  = (freqOut  >= prevFreq)  ? freqOut - prevFreq   : prevFreq - freqOut;
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rstN) !(busy && done));

  p_land_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && freqOut == capTarget));

  p_mono_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (distNow <= distPrev));

  p_stepmax_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (moveAbs <= capMag));

  p_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !busy && !bypass && holdFreq == targetFreq) |=>
      (done && !busy && freqOut == $past(targetFreq)));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !busy && bypass) |=>
      (done && !busy && exitBw != 2'b00 && freqOut == $past(targetFreq)));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && busy) |=> (exitBw == 2'b00));

endmodule

bind freq_exit_ramp frx_checker #(.FREQ_W(FREQ_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .holdFreq(holdFreq),
  .targetFreq(targetFreq), .stepCode(stepCode), .bypass(bypass),
  .busy(busy), .done(done), .freqOut(freqOut), .exitBw(exitBw)
);

// File: tb/sim_freq_exit_ramp.sv
module sim_freq_exit_ramp;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startStb = 1'b0;
  logic [W-1:0] holdFreq = '0;
  logic [W-1:0] targetFreq = '0;
  logic [2:0]   stepCode = '0;
  logic [2:0]   tickCode = '0;
  logic         bypass = 1'b0;
  logic [1:0]   bwSel = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] freqOut;
  logic [1:0]   exitBw;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  freq_exit_ramp #(.FREQ_W(W), .CODE_W(3)) u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .holdFreq(holdFreq),
    .targetFreq(targetFreq), .stepCode(stepCode), .tickCode(tickCode),
    .bypass(bypass), .bwSel(bwSel), .busy(busy), .done(done),
    .freqOut(freqOut), .exitBw(exitBw)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", int'({busy, done}), 0);
    chk(freqOut == '0, "R1", "freqOut in reset", int'(freqOut), 0);
    chk(exitBw == 2'b00, "R1", "exitBw in reset", int'(exitBw), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && freqOut == '0, "R1", "idle after reset",
        int'(freqOut), 0);
  endtask

  // Full ramp trace; optional mid-ramp start with changed inputs, and a start
  // that coincides with the final step.
  task automatic run_ramp(input int h, input int t, input int sc, input int tc,
                          input bit injMid, input bit injLast);
    int mag, per, diff, n, total, moved, ef;
    bit up;
    mag   = 1 << (2 * sc);
    per   = 1 << tc;
    up    = (t >= h);
    diff  = up ? t - h : h - t;
    n     = (diff + mag - 1) / mag;
    total = n * per;
    @(negedge clk);
    holdFreq = W'(h); targetFreq = W'(t);
    stepCode = 3'(sc); tickCode = 3'(tc);
    bypass = 1'b0; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    for (int j = 0; j <= total; j++) begin
      moved = (j / per) * mag;
      if (moved > diff) moved = diff;
      ef = up ? h + moved : h - moved;
      if (j == 0) begin
        chk(freqOut == W'(h), "R2", "first word equals hold", int'(freqOut), h);
        chk(busy == 1'b1 && done == 1'b0, "R2", "busy set, done cleared",
            int'({busy, done}), 2);
        chk(exitBw == 2'b00, "R2", "ramped exitBw", int'(exitBw), 0);
      end else begin
        chk(freqOut == W'(ef), (j < per) ? "R3" : "R4", "ramp word", int'(freqOut), ef);
        chk(busy == (j < total), "R5", "busy over ramp", int'(busy), int'(j < total));
        chk(done == (j == total), "R5", "done timing", int'(done), int'(j == total));
        if (injMid) chk(exitBw == 2'b00, "R9", "exitBw unaffected", int'(exitBw), 0);
      end
      if (injMid && j == 1) begin
        startStb = 1'b1; bypass = 1'b1;
        holdFreq = W'(12345); targetFreq = W'(999);
        stepCode = 3'd7; tickCode = 3'd0;
      end
      if (injMid && j == 2) begin
        startStb = 1'b0; bypass = 1'b0;
      end
      if (injLast && j == total - 1) startStb = 1'b1;
      if (j < total) @(negedge clk);
    end
    chk(freqOut == W'(t), "R5", "lands on target", int'(freqOut), t);
    startStb = 1'b0; bypass = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "start at final step ignored", int'(busy), 0);
    chk(done == 1'b1 && freqOut == W'(t), "R8", "done and word held", int'(freqOut), t);
  endtask

  task automatic t_zero();
    @(negedge clk);
    holdFreq = W'(4242); targetFreq = W'(4242);
    stepCode = 3'd2; tickCode = 3'd3; bypass = 1'b0; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R6", "zero diff done at once",
        int'({busy, done}), 1);
    chk(freqOut == W'(4242), "R6", "zero diff word", int'(freqOut), 4242);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R8", "done held while idle", int'(done), 1);
  endtask

  task automatic t_bypass();
    int expBw;
    for (int s = 0; s < 4; s++) begin
      expBw = (s == 0) ? 1 : (s == 1) ? 2 : 3;
      @(negedge clk);
      holdFreq = W'(100); targetFreq = W'(777 + s);
      stepCode = 3'd0; tickCode = 3'd0;
      bypass = 1'b1; bwSel = 2'(s); startStb = 1'b1;
      @(negedge clk);
      startStb = 1'b0; bypass = 1'b0;
      chk(exitBw == 2'(expBw), "R7", "bypass bandwidth code", int'(exitBw), expBw);
      chk(freqOut == W'(777 + s), "R7", "bypass jumps to target", int'(freqOut), 777 + s);
      chk(done == 1'b1 && busy == 1'b0, "R7", "bypass done", int'({busy, done}), 1);
    end
  endtask

  initial begin
    t_reset();
    run_ramp(1000, 1050, 1, 2, 1'b1, 1'b0);   // up, clipped last step
    run_ramp(5000, 4000, 2, 0, 1'b0, 1'b1);   // down, start on final step
    run_ramp(0, 20000, 3, 1, 1'b1, 1'b1);     // long up, both collisions
    run_ramp(300, 200, 1, 3, 1'b0, 1'b0);     // down, exact multiple
    t_zero();
    t_bypass();
    run_ramp(2000, 2100, 0, 1, 1'b0, 1'b0);   // ramp after bypass restores 00
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule